// File: doc/BRIEF.md
# APB Watchdog Timer

This block is a 32-bit down-counting watchdog reached through an APB slave port. Software programs a reload value, then sets the enable bit in the control register. That bit both starts the counter and unmasks the interrupt. The counter steps down by one on every clock cycle in which the external `tick_en` strobe is high. The tick rate is therefore set entirely by whatever drives that strobe, and it may change at run time.

When the count steps down to zero, the raw interrupt flag is set and the count reads zero. On the next tick the count reloads from the load register. Software services the watchdog by writing any data to the clear register. If the interrupt is still pending the next time the count reaches zero, and the reset-request bit is set, the block pulses a one-cycle reset request.

A write lock protects all registers, and it is active out of reset. A build-time parameter selects a sticky variant. In that variant, once the enable bit has been set, the control register cannot be changed again until reset.

Top module: `wdt_apb`

Register offsets used throughout: load 0x000, count 0x004, control 0x008 (bit 0 run/interrupt enable, bit 1 reset-request enable), clear 0x00C, raw status 0x010 (bit 0), masked status 0x014 (bit 0), lock 0xC00.

## Requirements
- R1: After reset, load and count read 0xFFFFFFFF, control reads 0, raw status reads 0, lock reads 1, and the count does not move until control bit 0 is written to 1.
- R2: While locked, writes to every register except the lock register are ignored. Writing 0x1ACCE551 to the lock register unlocks. Writing any other value relocks. The lock register reads 1 when locked and 0 when unlocked.
- R3: While control bit 0 is 1, the count drops by exactly one per cycle with `tick_en` high. While control bit 0 is 0, the count holds for any number of ticks.
- R4: A load write sets the count to the written value on the next read, whether or not counting is enabled.
- R5: A tick that takes the count from 1 to 0 sets raw status bit 0, and the count then reads 0. The next tick reloads the count from the load register.
- R6: A write of any data to the clear register clears raw status and reloads the count from the load register.
- R7: Writing control bit 0 as 1 while it is 0 reloads the count from the load register. Writing it as 0 freezes the count.
- R8: Masked status bit 0 and the `irq` output both equal raw status AND control bit 0.
- R9: With control bit 1 set, a tick that takes the count to zero while raw status is already 1 drives `rst_req` high for exactly one cycle. A zero reached with raw status clear gives no pulse.
- R10: With STICKY=1, control writes are ignored once bit 0 is 1. Bit 0 then reads 1, and counting continues until reset.
- R11: `pready` is always 1 and `pslverr` is always 0, and reads of unmapped offsets return 0.
- R12: A register write that lands in the same cycle as a tick takes priority over that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| tick_en | input | 1 | Count strobe, one decrement per high cycle |
| irq | output | 1 | Masked interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench builds two copies of the block. One uses STICKY=0 and runs the vector table: lock handling, the hold, decrement and reload paths, the clear, the enable toggles, and the reset-request pulse. The other uses STICKY=1, which is the only build that can show a control write being refused while counting continues. A mid-run reset of both copies then confirms that the defaults return and that the count stays still afterwards.

// File: rtl/wdt_pkg.sv
// Package: register offsets and constants shared by the watchdog modules.
// Assumes a 12-bit byte offset space and 32-bit data.
package wdt_pkg;
    localparam int AW = 12;
    localparam logic [AW-1:0] OFS_LOAD  = 12'h000;
    localparam logic [AW-1:0] OFS_COUNT = 12'h004;
    localparam logic [AW-1:0] OFS_CTRL  = 12'h008;
    localparam logic [AW-1:0] OFS_CLEAR = 12'h00C;
    localparam logic [AW-1:0] OFS_RAW   = 12'h010;
    localparam logic [AW-1:0] OFS_MASK  = 12'h014;
    localparam logic [AW-1:0] OFS_LOCK  = 12'hC00;
    localparam logic [31:0]   UNLOCK_KEY = 32'h1ACC_E551;
endpackage

// File: rtl/wdt_regfile.sv
// Register file: APB decode, lock, control and load registers, read mux.
// Assumes a zero-wait-state APB (writes commit in the access phase).
// STICKY selects the variant whose control register freezes once enabled.
module wdt_regfile #(
    parameter int DW     = 32,
    parameter bit STICKY = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [wdt_pkg::AW-1:0] paddr,
    input  logic [DW-1:0]        pwdata,
    output logic [DW-1:0]        prdata,
    input  logic [DW-1:0]        cnt,
    input  logic                 ris,
    output logic [DW-1:0]        load_q,
    output logic                 run_en,
    output logic                 rst_en,
    output logic                 load_wr,
    output logic                 clr_req,
    output logic                 reload_req
);
    import wdt_pkg::*;

    logic locked_q;
    logic wr_acc;
    logic ctrl_wr;
    logic ctrl_wr_ok;

    assign wr_acc  = psel & penable & pwrite;
    assign load_wr = wr_acc & ~locked_q & (paddr == OFS_LOAD);
    assign clr_req = wr_acc & ~locked_q & (paddr == OFS_CLEAR);
    assign ctrl_wr = wr_acc & ~locked_q & (paddr == OFS_CTRL);

    // Variant select: the sticky build refuses control writes once running (R10).
    generate
        if (STICKY) begin : g_sticky
            assign ctrl_wr_ok = ctrl_wr & ~run_en;
        end else begin : g_plain
            assign ctrl_wr_ok = ctrl_wr;
        end
    endgenerate

    // An accepted 0->1 enable write asks the counter to reload (R7).
    assign reload_req = ctrl_wr_ok & pwdata[0] & ~run_en;

    // Lock register: the key unlocks it, any other value relocks it (R2).
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked_q <= 1'b1;
        else if (wr_acc && paddr == OFS_LOCK)
            locked_q <= (pwdata != DW'(UNLOCK_KEY));
    end

    // Load register: holds the reload value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            load_q <= '1;
        else if (load_wr)
            load_q <= pwdata;
    end

    // Control register: bit 0 is run/interrupt enable, bit 1 is reset-request enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en <= 1'b0;
            rst_en <= 1'b0;
        end else if (ctrl_wr_ok) begin
            run_en <= pwdata[0];
            rst_en <= pwdata[1];
        end
    end

    // Read mux: unmapped offsets return zero (R11).
    always_comb begin
        prdata = '0;
        case (paddr)
            OFS_LOAD:  prdata = load_q;
            OFS_COUNT: prdata = cnt;
            OFS_CTRL:  prdata = {{(DW-2){1'b0}}, rst_en, run_en};
            OFS_RAW:   prdata = {{(DW-1){1'b0}}, ris};
            OFS_MASK:  prdata = {{(DW-1){1'b0}}, ris & run_en};
            OFS_LOCK:  prdata = {{(DW-1){1'b0}}, locked_q};
            default:   prdata = '0;
        endcase
    end

    // R2: a locked load write leaves the load register untouched.
    assert_locked_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && wr_acc && paddr == OFS_LOAD) |=> $stable(load_q));

    generate
        if (STICKY) begin : g_sticky_chk
            // R10: once set, the enable stays set until reset.
            assert_enable_sticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
                run_en |=> run_en);
        end
    endgenerate
endmodule

// File: rtl/wdt_core.sv
// Counter core: down-counter, raw interrupt flag and reset-request pulse.
// Priority per cycle: load write, then clear, then enable reload, then tick (R12).
module wdt_core #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          run_en,
    input  logic          rst_en,
    input  logic [DW-1:0] load_val,
    input  logic [DW-1:0] wdata,
    input  logic          load_wr,
    input  logic          clr_req,
    input  logic          reload_req,
    output logic [DW-1:0] cnt,
    output logic          ris,
    output logic          rst_req
);
    localparam logic [DW-1:0] ONE = DW'(1);

    logic any_wr;
    logic step;
    logic hit_zero;

    assign any_wr   = load_wr | clr_req | reload_req;
    assign step     = run_en & tick_en & ~any_wr;
    assign hit_zero = step & (cnt == ONE);

    // Count register: loads, reloads, or steps down on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '1;
        else if (load_wr)
            cnt <= wdata;
        else if (clr_req || reload_req)
            cnt <= load_val;
        else if (step)
            cnt <= (cnt == '0) ? load_val : cnt - ONE;
    end

    // Raw interrupt flag: set on reaching zero, cleared by the clear write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ris <= 1'b0;
        else if (clr_req)
            ris <= 1'b0;
        else if (hit_zero)
            ris <= 1'b1;
    end

    // Reset request: one cycle when zero is reached with the flag already pending.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_req <= 1'b0;
        else
            rst_req <= hit_zero & ris & rst_en;
    end

    // R3: with counting off and no writes, the count holds.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !any_wr) |=> $stable(cnt));
    // R3: a tick on a nonzero count drops it by one.
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt != '0) |=> (cnt == $past(cnt) - ONE));
    // R5: stepping to zero raises the raw flag.
    assert_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_zero |=> (ris && cnt == '0));
    // R6: the clear write drops the flag and reloads.
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !load_wr) |=> (!ris && cnt == $past(load_val)));
    // R9: the reset request lasts a single cycle.
    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
endmodule

// File: rtl/wdt_apb.sv
// Top: APB watchdog timer. Joins the register file and counter core.
// Assumes tick_en is synchronous to clk; always zero wait states.
module wdt_apb #(
    parameter int DW     = 32,
    parameter bit STICKY = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [11:0]   paddr,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] prdata,
    output logic          pready,
    output logic          pslverr,
    input  logic          tick_en,
    output logic          irq,
    output logic          rst_req
);
    logic [DW-1:0] cnt, load_q;
    logic ris, run_en, rst_en, load_wr, clr_req, reload_req;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign irq     = ris & run_en;

    wdt_regfile #(.DW(DW), .STICKY(STICKY)) u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cnt(cnt), .ris(ris),
        .load_q(load_q), .run_en(run_en), .rst_en(rst_en), .load_wr(load_wr),
        .clr_req(clr_req), .reload_req(reload_req)
    );

    wdt_core #(.DW(DW)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_en(run_en), .rst_en(rst_en),
        .load_val(load_q), .wdata(pwdata), .load_wr(load_wr), .clr_req(clr_req),
        .reload_req(reload_req), .cnt(cnt), .ris(ris), .rst_req(rst_req)
    );

    // R8: the interrupt output never shows while counting is disabled.
    assert_irq_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> run_en);
    // R9: a reset request only follows a pending interrupt.
    assert_req_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ris);
endmodule

// File: tb/sim_wdt_apb.sv
// Bench: u0 (STICKY=0) walks a vector table, then directed tests; u1 is sticky.
module sim_wdt_apb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psel0 = 1'b0, psel1 = 1'b0, penable = 1'b0, pwrite = 1'b0, tick_en = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata0, prdata1;
    logic pready0, pslverr0, irq0, rstreq0, pready1, pslverr1, irq1, rstreq1;
    int nchk = 0, nfail = 0;
    logic [31:0] rd;
    logic rd_rdy, rd_err;

    always #10 clk = ~clk;

    wdt_apb #(.DW(32), .STICKY(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel0), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata0), .pready(pready0),
        .pslverr(pslverr0), .tick_en(tick_en), .irq(irq0), .rst_req(rstreq0));
    wdt_apb #(.DW(32), .STICKY(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .psel(psel1), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata1), .pready(pready1),
        .pslverr(pslverr1), .tick_en(tick_en), .irq(irq1), .rst_req(rstreq1));

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;
    localparam logic [31:0] KEY = 32'h1ACC_E551;
    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;
    localparam int NV = 42;
    localparam vec_t TBL [NV] = '{
        '{OP_RD, 12'hC00, 32'd0,   32'd1,          4'd1},  // R1 locked out of reset
        '{OP_RD, 12'h000, 32'd0,   32'hFFFF_FFFF,  4'd1},  // R1
        '{OP_RD, 12'h004, 32'd0,   32'hFFFF_FFFF,  4'd1},  // R1
        '{OP_RD, 12'h008, 32'd0,   32'd0,          4'd1},  // R1
        '{OP_RD, 12'h010, 32'd0,   32'd0,          4'd1},  // R1
        '{OP_WR, 12'h000, 32'd100, 32'd0,          4'd0},
        '{OP_RD, 12'h000, 32'd0,   32'hFFFF_FFFF,  4'd2},  // R2 write ignored
        '{OP_WR, 12'hC00, KEY,     32'd0,          4'd0},
        '{OP_RD, 12'hC00, 32'd0,   32'd0,          4'd2},  // R2 unlocked
        '{OP_WR, 12'h000, 32'd1000,32'd0,          4'd0},
        '{OP_RD, 12'h004, 32'd0,   32'd1000,       4'd4},  // R4 disabled load
        '{OP_TK, 12'h000, 32'd50,  32'd0,          4'd0},
        '{OP_RD, 12'h004, 32'd0,   32'd1000,       4'd3},  // R3 hold
        '{OP_WR, 12'h008, 32'd1,   32'd0,          4'd0},
        '{OP_TK, 12'h000, 32'd500, 32'd0,          4'd0},
        '{OP_RD, 12'h004, 32'd0,   32'd500,        4'd3},  // R3 decrement
        '{OP_RD, 12'h010, 32'd0,   32'd0,          4'd5},  // R5
        '{OP_TK, 12'h000, 32'd500, 32'd0,          4'd0},
        '{OP_RD, 12'h004, 32'd0,   32'd0,          4'd5},  // R5 at zero
        '{OP_RD, 12'h010, 32'd0,   32'd1,          4'd5},  // R5 flag
        '{OP_RD, 12'h014, 32'd0,   32'd1,          4'd8},  // R8 masked
        '{OP_TK, 12'h000, 32'd1,   32'd0,          4'd0},
        '{OP_RD, 12'h004, 32'd0,   32'd1000,       4'd5},  // R5 reload
        '{OP_TK, 12'h000, 32'd500, 32'd0,          4'd0},
        '{OP_RD, 12'h004, 32'd0,   32'd500,        4'd3},  // R3
        '{OP_WR, 12'h00C, 32'hDEAD,32'd0,          4'd0},
        '{OP_RD, 12'h004, 32'd0,   32'd1000,       4'd6},  // R6 reload
        '{OP_RD, 12'h010, 32'd0,   32'd0,          4'd6},  // R6 cleared
        '{OP_TK, 12'h000, 32'd100, 32'd0,          4'd0},
        '{OP_WR, 12'h008, 32'd0,   32'd0,          4'd0},
        '{OP_TK, 12'h000, 32'd100, 32'd0,          4'd0},
        '{OP_RD, 12'h004, 32'd0,   32'd900,        4'd7},  // R7 frozen
        '{OP_WR, 12'h008, 32'd1,   32'd0,          4'd0},
        '{OP_RD, 12'h004, 32'd0,   32'd1000,       4'd7},  // R7 re-enable reload
        '{OP_RD, 12'hFF0, 32'd0,   32'd0,          4'd11}, // R11 unmapped
        '{OP_WR, 12'hC00, 32'd5,   32'd0,          4'd0},
        '{OP_RD, 12'hC00, 32'd0,   32'd1,          4'd2},  // R2 relocked
        '{OP_WR, 12'h000, 32'd7,   32'd0,          4'd0},
        '{OP_RD, 12'h000, 32'd0,   32'd1000,       4'd2},  // R2
        '{OP_WR, 12'hC00, KEY,     32'd0,          4'd0},
        '{OP_WR, 12'h000, 32'd3,   32'd0,          4'd0},
        '{OP_RD, 12'h004, 32'd0,   32'd3,          4'd4}   // R4 enabled load
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL R%0d: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input bit which, input logic [11:0] a, input logic [31:0] d);
        psel0 = ~which; psel1 = which; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel0 = 1'b0; psel1 = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input bit which, input logic [11:0] a);
        psel0 = ~which; psel1 = which; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk); penable = 1'b1;
        #1;
        rd = which ? prdata1 : prdata0;
        rd_rdy = which ? pready1 : pready0;
        rd_err = which ? pslverr1 : pslverr0;
        @(negedge clk); psel0 = 1'b0; psel1 = 1'b0; penable = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic finish_run;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        nchk++; nfail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            case (TBL[i].op)
                OP_WR: apb_wr(1'b0, TBL[i].addr, TBL[i].data);
                OP_RD: begin
                    apb_rd(1'b0, TBL[i].addr);
                    check(int'(TBL[i].req), rd, TBL[i].exp);
                end
                default: ticks(int'(TBL[i].data));
            endcase
        end
        // R11: handshake outputs during an access.
        apb_rd(1'b0, 12'h004);
        check(11, {30'd0, rd_rdy, rd_err}, 32'd2);
        // R12: load write in a tick cycle wins; count shows written value.
        tick_en = 1'b1; apb_wr(1'b0, 12'h000, 32'd3); tick_en = 1'b0;
        apb_rd(1'b0, 12'h004); check(12, rd, 32'd3);
        // R9: reset-request enable on; first zero gives no pulse.
        apb_wr(1'b0, 12'h008, 32'd3);
        ticks(3);
        check(8, {31'd0, irq0}, 32'd1);      // R8 irq follows flag
        check(9, {31'd0, rstreq0}, 32'd0);   // R9 no pulse on first zero
        ticks(3);
        ticks(1);
        check(9, {31'd0, rstreq0}, 32'd1);   // R9 pulse on second zero
        @(negedge clk);
        check(9, {31'd0, rstreq0}, 32'd0);   // R9 single cycle
        apb_wr(1'b0, 12'h008, 32'd0);
        check(8, {31'd0, irq0}, 32'd0);      // R8 masked off
        apb_rd(1'b0, 12'h010); check(8, rd, 32'd1);
        apb_rd(1'b0, 12'h014); check(8, rd, 32'd0);
        // R10: sticky variant on u1.
        apb_wr(1'b1, 12'hC00, KEY);
        apb_wr(1'b1, 12'h000, 32'd4000);
        apb_wr(1'b1, 12'h008, 32'd1);
        ticks(500);
        apb_rd(1'b1, 12'h004); check(10, rd, 32'd3500);
        apb_wr(1'b1, 12'h008, 32'd0);
        ticks(100);
        apb_rd(1'b1, 12'h004); check(10, rd, 32'd3400);
        apb_rd(1'b1, 12'h008); check(10, rd, 32'd1);
        // R1: reset mid-run returns defaults and stops the count.
        rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1;
        apb_rd(1'b1, 12'h008); check(1, rd, 32'd0);
        apb_rd(1'b1, 12'hC00); check(1, rd, 32'd1);
        apb_rd(1'b1, 12'h000); check(1, rd, 32'hFFFF_FFFF);
        ticks(100);
        apb_rd(1'b1, 12'h004); check(1, rd, 32'hFFFF_FFFF);
        apb_rd(1'b0, 12'h004); check(1, rd, 32'hFFFF_FFFF);
        apb_rd(1'b0, 12'h010); check(1, rd, 32'd0);
        finish_run();
    end
endmodule